// File: doc/BRIEF.md
# Flash Command Sequencer

The block is the command front end of an on-chip flash memory. It sits between a 16-bit CPU bus and a flash array back end. CPU writes to even addresses inside the user ROM window are decoded as one- or two-cycle command sequences. Only the low byte of a written word is decoded. The sequencer keeps a sticky read mode, so a CPU read returns one of three things: the array word at the address, the status register, or the lock bit of the addressed block.

Program, block erase and lock-bit program sequences become one request to the back end. Each request carries an operation kind, an address and a data word, and is sent on a valid/ready channel. The request is held, with all its fields unchanged, until the back end raises `op_ready`. The back end does not need to accept at once. After accepting, it reports the end of the operation with a one-cycle `done_valid` pulse, which carries a pass/fail flag.

While an operation is outstanding, the block reports not-ready, and every command write is ignored. A failed operation, or a rejected confirm code, sets error bits. These bits stay set until a clear-status command is written.

Top module: `flash_cmd_seq`

## Requirements
- R1: A write is decoded from `bus_wdata[7:0]` only; bits 15:8 never change the result. The command codes are FFh (read array), 70h (read status), 71h (read lock), 50h (clear status), 40h (program), 20h (block erase) and 77h (lock-bit program). D0h is the confirm code. Any other code written as a first cycle is ignored.
- R2: An access is valid only if `bus_addr` is even and not below `ROM_LO`. A write to an invalid address has no effect. A read from an invalid address, or any cycle without `bus_rd`, returns 0000h.
- R3: After reset, and after FFh, the block is in array read mode. Each valid read in this mode returns `arr_rdata` for the read address. The mode lasts until another mode-changing command is accepted.
- R4: After 70h, each valid read returns the status byte zero-extended to 16 bits. Bit 7 is ready (1 = idle), bit 5 is the erase/lock error, bit 4 is the program error, and all other bits are 0.
- R5: After 71h, each valid read returns `lock_bit` for the read address in bit 0, with bits 15:1 at 0.
- R6: The sequence 40h followed by a data write issues one request with `op_kind` 0. The request carries the second write's address and all 16 bits of its data.
- R7: The sequence 20h then D0h issues one request with `op_kind` 1. The sequence 77h then D0h issues one request with `op_kind` 2. Each request carries the confirm write's address. If the second write of either sequence is not D0h, no request is issued, both error bits are set, and the read mode becomes status.
- R8: `op_valid` holds its kind, address and data stable until `op_ready`. From the second command write until `done_valid`, `flash_ready` is 0 and status bit 7 reads 0. Command writes made in that interval are ignored.
- R9: After `done_valid`, `flash_ready` returns to 1 and the read mode is status. `done_fail` sets the program error for kind 0 and the erase/lock error for kinds 1 and 2. Error bits stay set until they are cleared.
- R10: 50h clears both error bits and `err_flags` (bit 1 = erase/lock error, bit 0 = program error) and does not change the read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| bus_addr | input | AW | CPU byte address |
| bus_wdata | input | 16 | CPU write word |
| bus_rdata | output | 16 | CPU read word (combinational) |
| arr_raddr | output | AW | Array/lock lookup address |
| arr_rdata | input | 16 | Array word at `arr_raddr` |
| lock_bit | input | 1 | Lock state of the block at `arr_raddr` |
| op_valid | output | 1 | Back-end request valid |
| op_ready | input | 1 | Back end accepts the request |
| op_kind | output | 2 | 0 program, 1 erase, 2 lock |
| op_addr | output | AW | Request address |
| op_data | output | 16 | Request data (program only) |
| done_valid | input | 1 | One-cycle completion pulse |
| done_fail | input | 1 | Completion result, 1 = failed |
| flash_ready | output | 1 | 1 when no operation is outstanding |
| err_flags | output | 2 | Copies of the two error bits |

## Verification
The bench sweeps every possible low-byte code through the command state and checks that the ignored codes leave array reads intact and issue no request. A decoder that compared all 16 bits, or that let a stray code start a sequence, would break this. It also sweeps high bytes on the status and confirm writes. The bench polls status while the back end holds off `op_ready` and while it is busy, and writes commands into that interval. A design that cleared ready too late, or accepted those writes, would show a set bit 7 or a changed read mode. Bad confirm codes, odd addresses and addresses below the window are driven to catch a block that still issues a request, or decodes a stray write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {RM_ARRAY = 2'd0, RM_STATUS = 2'd1, RM_LOCK = 2'd2} rmode_t;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_ERASE = 2'd1, OP_LOCK = 2'd2} op_kind_t;
  typedef enum logic [2:0] {S_CMD, S_PDATA, S_ECONF, S_LCONF, S_ISSUE, S_WAIT} seq_t;

  localparam logic [7:0] C_ARRAY   = 8'hFF;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_LOCKRD  = 8'h71;
  localparam logic [7:0] C_CLEAR   = 8'h50;
  localparam logic [7:0] C_PROG    = 8'h40;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_LOCKPG  = 8'h77;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          op_ready,
  input  logic          done_valid,
  input  logic          done_fail,
  output rmode_t        rmode,
  output logic          op_valid,
  output logic [1:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [15:0]   op_data,
  output logic          busy,
  output logic          clr_req,
  output logic          bad_conf,
  output logic          fail_prog,
  output logic          fail_blk
);
  seq_t       st;
  op_kind_t   kind_q;
  logic [7:0] code;

  assign code = wr_data[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_CMD;
      rmode   <= RM_ARRAY;
      kind_q  <= OP_PROG;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      case (st)
        S_CMD: if (wr_ok) begin
          case (code)
            C_ARRAY:  rmode <= RM_ARRAY;
            C_STATUS: rmode <= RM_STATUS;
            C_LOCKRD: rmode <= RM_LOCK;
            C_PROG:   st    <= S_PDATA;
            C_ERASE:  st    <= S_ECONF;
            C_LOCKPG: st    <= S_LCONF;
            default:  ;
          endcase
        end
        S_PDATA: if (wr_ok) begin
          kind_q  <= OP_PROG;
          op_addr <= wr_addr;
          op_data <= wr_data;
          rmode   <= RM_STATUS;
          st      <= S_ISSUE;
        end
        S_ECONF, S_LCONF: if (wr_ok) begin
          rmode <= RM_STATUS;
          if (code == C_CONFIRM) begin
            kind_q  <= (st == S_ECONF) ? OP_ERASE : OP_LOCK;
            op_addr <= wr_addr;
            op_data <= '0;
            st      <= S_ISSUE;
          end else begin
            st <= S_CMD;
          end
        end
        S_ISSUE: if (op_ready) st <= S_WAIT;
        S_WAIT:  if (done_valid) st <= S_CMD;
        default: st <= S_CMD;
      endcase
    end
  end

  assign op_valid  = (st == S_ISSUE);
  assign op_kind   = kind_q;
  assign busy      = (st == S_ISSUE) || (st == S_WAIT);
  assign clr_req   = wr_ok && (st == S_CMD) && (code == C_CLEAR);
  assign bad_conf  = wr_ok && ((st == S_ECONF) || (st == S_LCONF)) && (code != C_CONFIRM);
  assign fail_prog = (st == S_WAIT) && done_valid && done_fail && (kind_q == OP_PROG);
  assign fail_blk  = (st == S_WAIT) && done_valid && done_fail && (kind_q != OP_PROG);
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       clr_req,
  input  logic       bad_conf,
  input  logic       fail_prog,
  input  logic       fail_blk,
  output logic [7:0] sr,
  output logic [1:0] err_flags
);
  logic blk_err, prg_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_err <= 1'b0;
      prg_err <= 1'b0;
    end else if (clr_req) begin
      blk_err <= 1'b0;
      prg_err <= 1'b0;
    end else begin
      blk_err <= blk_err | bad_conf | fail_blk;
      prg_err <= prg_err | bad_conf | fail_prog;
    end
  end

  assign sr        = {~busy, 1'b0, blk_err, prg_err, 4'b0000};
  assign err_flags = {blk_err, prg_err};
endmodule

// File: rtl/flash_cmd_rdmux.sv
module flash_cmd_rdmux
  import flash_cmd_pkg::*;
(
  input  logic        rd_ok,
  input  rmode_t      rmode,
  input  logic [15:0] arr_rdata,
  input  logic [7:0]  sr,
  input  logic        lock_bit,
  output logic [15:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      case (rmode)
        RM_ARRAY:  rdata = arr_rdata;
        RM_STATUS: rdata = {8'h00, sr};
        RM_LOCK:   rdata = {15'd0, lock_bit};
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int            AW     = 16,
  parameter logic [AW-1:0] ROM_LO = 16'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic [AW-1:0] arr_raddr,
  input  logic [15:0]   arr_rdata,
  input  logic          lock_bit,
  output logic          op_valid,
  input  logic          op_ready,
  output logic [1:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [15:0]   op_data,
  input  logic          done_valid,
  input  logic          done_fail,
  output logic          flash_ready,
  output logic [1:0]    err_flags
);
  logic   in_win, wr_ok, rd_ok;
  logic   busy, clr_req, bad_conf, fail_prog, fail_blk;
  rmode_t rmode;
  logic [7:0] sr;

  assign in_win    = !bus_addr[0] && (bus_addr >= ROM_LO);
  assign wr_ok     = bus_wr && in_win;
  assign rd_ok     = bus_rd && in_win;
  assign arr_raddr = bus_addr;

  flash_cmd_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .op_ready(op_ready), .done_valid(done_valid), .done_fail(done_fail),
    .rmode(rmode), .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .busy(busy), .clr_req(clr_req), .bad_conf(bad_conf),
    .fail_prog(fail_prog), .fail_blk(fail_blk)
  );

  flash_cmd_status u_stat (
    .clk(clk), .rst_n(rst_n), .busy(busy), .clr_req(clr_req), .bad_conf(bad_conf),
    .fail_prog(fail_prog), .fail_blk(fail_blk), .sr(sr), .err_flags(err_flags)
  );

  flash_cmd_rdmux u_mux (
    .rd_ok(rd_ok), .rmode(rmode), .arr_rdata(arr_rdata), .sr(sr),
    .lock_bit(lock_bit), .rdata(bus_rdata)
  );

  assign flash_ready = ~busy;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [15:0]   bus_wdata,
  input logic [15:0]   bus_rdata,
  input logic          op_valid,
  input logic          op_ready,
  input logic [1:0]    op_kind,
  input logic [AW-1:0] op_addr,
  input logic [15:0]   op_data,
  input logic          done_valid,
  input logic          done_fail,
  input logic          flash_ready,
  input logic [1:0]    err_flags
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_addr) && $stable(op_data) && $stable(op_kind));

  assert_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !flash_ready);

  assert_bad_addr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[0] || !bus_rd) |-> bus_rdata == 16'h0000);

  assert_req_from_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> $past(bus_wr));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != 2'b00) && !(bus_wr && bus_wdata[7:0] == 8'h50) |=> err_flags != 2'b00);

  assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !flash_ready |=> flash_ready);

  assert_fail_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_fail && !flash_ready |=> err_flags != 2'b00);
endmodule

bind flash_cmd_seq flash_cmd_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .op_valid(op_valid), .op_ready(op_ready),
  .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data), .done_valid(done_valid),
  .done_fail(done_fail), .flash_ready(flash_ready), .err_flags(err_flags)
);

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/1ps
module flash_cmd_seq_bench;
  localparam int AW = 16;
  localparam int READY_LAT = 2;
  localparam int BUSY_CYC  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic [AW-1:0] arr_raddr;
  logic [15:0]   arr_rdata;
  logic          lock_bit;
  logic          op_valid, op_ready = 1'b0;
  logic [1:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [15:0]   op_data;
  logic          done_valid = 1'b0, done_fail = 1'b0;
  logic          flash_ready;
  logic [1:0]    err_flags;

  int n_chk = 0, n_bad = 0, op_cnt = 0;
  logic [1:0]    last_kind;
  logic [AW-1:0] last_addr;
  logic [15:0]   last_data;
  logic          fail_next = 1'b0;
  logic          finished = 1'b0;
  logic [15:0]   rv;

  always #4 clk = ~clk;

  assign arr_rdata = arr_raddr ^ 16'h5A3C;
  assign lock_bit  = arr_raddr[10] ^ arr_raddr[9];

  flash_cmd_seq u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_raddr(arr_raddr),
    .arr_rdata(arr_rdata), .lock_bit(lock_bit), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data), .done_valid(done_valid),
    .done_fail(done_fail), .flash_ready(flash_ready), .err_flags(err_flags)
  );

  function automatic logic [15:0] st_word(input logic rdy, input logic e5, input logic e4);
    return {8'h00, rdy, 1'b0, e5, e4, 4'b0000};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 rv = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!flash_ready);
  endtask

  // behavioural back end: holds off ready, then stays busy, then reports
  initial begin
    forever begin
      @(negedge clk);
      if (op_valid) begin
        last_kind = op_kind; last_addr = op_addr; last_data = op_data;
        op_cnt++;
        for (int i = 0; i < READY_LAT; i++) begin
          @(negedge clk);
          chk("R8 request held", {op_valid, op_kind, op_addr[12:0]},
              {1'b1, last_kind, last_addr[12:0]});
        end
        op_ready = 1'b1;
        @(negedge clk);
        op_ready = 1'b0;
        repeat (BUSY_CYC) @(negedge clk);
        done_fail = fail_next; done_valid = 1'b1;
        @(negedge clk);
        done_valid = 1'b0; done_fail = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ops0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset ready", {15'd0, flash_ready}, 16'd1);
    chk("R10 reset flags", {14'd0, err_flags}, 16'd0);
    chk("R8 reset no request", {15'd0, op_valid}, 16'd0);

    // R3: array mode after reset, sweep of a stretch of words
    for (int a = 16'h8000; a < 16'h8100; a += 2) begin
      rd(a[15:0]);
      chk("R3 array read", rv, a[15:0] ^ 16'h5A3C);
    end
    rd(16'h8001); chk("R2 odd read zero", rv, 16'h0000);
    rd(16'h7FFE); chk("R2 low read zero", rv, 16'h0000);

    // R1/R4: high byte sweep on status and array commands
    for (int hb = 0; hb < 256; hb += 5) begin
      wr(16'h8000, {hb[7:0], 8'h70});
      rd(16'h8ABC); chk("R4 status read hb", rv, st_word(1, 0, 0));
      wr(16'hFFFE, {hb[7:0], 8'hFF});
      rd(16'h8ABC); chk("R1 array read hb", rv, 16'h8ABC ^ 16'h5A3C);
    end

    // R2: rejected writes
    wr(16'h8001, 16'h0070); rd(16'h8010); chk("R2 odd write ignored", rv, 16'h8010 ^ 16'h5A3C);
    wr(16'h7FFE, 16'h0070); rd(16'h8010); chk("R2 low write ignored", rv, 16'h8010 ^ 16'h5A3C);

    // R5: lock read
    wr(16'h8000, 16'h3371);
    for (int a = 16'h8000; a < 16'h9000; a += 16'h0100) begin
      rd(a[15:0]);
      chk("R5 lock read", rv, {15'd0, a[10] ^ a[9]});
    end
    wr(16'h8000, 16'h00FF);

    // R1: every undefined code is ignored
    ops0 = op_cnt;
    for (int c = 0; c < 256; c++) begin
      if (!(c inside {8'hFF, 8'h70, 8'h71, 8'h50, 8'h40, 8'h20, 8'h77})) begin
        wr(16'h8000, {8'h12, c[7:0]});
        rd(16'h8010); chk("R1 unknown code ignored", rv, 16'h8010 ^ 16'h5A3C);
      end
    end
    repeat (4) @(negedge clk);
    chk("R1 unknown code no request", op_cnt[15:0], ops0[15:0]);

    // R6/R8/R9: program with busy polling and ignored writes
    ops0 = op_cnt;
    wr(16'h9000, 16'hFF40);
    wr(16'h9000, 16'hBEEF);
    rd(16'h8000); chk("R8 busy status", rv, st_word(0, 0, 0));
    wr(16'h8000, 16'h00FF);
    rd(16'h8000); chk("R8 write ignored while busy", rv, st_word(0, 0, 0));
    wait_idle();
    chk("R6 one request", op_cnt[15:0], ops0[15:0] + 16'd1);
    chk("R6 kind", {14'd0, last_kind}, 16'd0);
    chk("R6 addr", last_addr, 16'h9000);
    chk("R6 data", last_data, 16'hBEEF);
    rd(16'h8000); chk("R9 status after done", rv, st_word(1, 0, 0));

    // R9: program failure
    fail_next = 1'b1;
    wr(16'hA002, 16'h0040); wr(16'hA002, 16'h0001);
    wait_idle(); fail_next = 1'b0;
    rd(16'h8000); chk("R9 program fail", rv, st_word(1, 0, 1));
    chk("R9 flags program", {14'd0, err_flags}, 16'd1);

    // R10: clear
    wr(16'h8000, 16'hEE50);
    rd(16'h8000); chk("R10 cleared status", rv, st_word(1, 0, 0));
    chk("R10 cleared flags", {14'd0, err_flags}, 16'd0);

    // R7: erase with a high byte on the confirm, failing
    fail_next = 1'b1;
    wr(16'h8000, 16'h0020); wr(16'h8FFE, 16'hA5D0);
    wait_idle(); fail_next = 1'b0;
    chk("R7 erase kind", {14'd0, last_kind}, 16'd1);
    chk("R7 erase addr", last_addr, 16'h8FFE);
    rd(16'h8000); chk("R9 erase fail", rv, st_word(1, 1, 0));
    wr(16'h8000, 16'h0050);

    // R7: lock-bit program, passing
    wr(16'h8000, 16'h0077); wr(16'hBFFE, 16'h00D0);
    wait_idle();
    chk("R7 lock kind", {14'd0, last_kind}, 16'd2);
    chk("R7 lock addr", last_addr, 16'hBFFE);
    rd(16'h8000); chk("R9 lock pass", rv, st_word(1, 0, 0));

    // R7: bad confirms
    ops0 = op_cnt;
    wr(16'h8000, 16'h00FF);
    wr(16'h8000, 16'h0020); wr(16'h8FFE, 16'h00C0);
    rd(16'h8000); chk("R7 bad erase confirm", rv, st_word(1, 1, 1));
    wr(16'h8000, 16'h0050);
    wr(16'h8000, 16'h00FF);
    wr(16'h8000, 16'h0077); wr(16'h8FFE, 16'hD000);
    rd(16'h8000); chk("R7 bad lock confirm", rv, st_word(1, 1, 1));
    chk("R7 bad confirm flags", {14'd0, err_flags}, 16'd3);
    repeat (4) @(negedge clk);
    chk("R7 bad confirm no request", op_cnt[15:0], ops0[15:0]);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule